// File: doc/BRIEF.md
# Flow-controlled TPM register target on SPI

This block is the target side of an SPI link (mode 0: MOSI sampled on the rising SCLK edge, MISO changed on the falling edge) that a host uses to read and write a security chip's registers. Each transaction opens with four header bytes that give the direction, the length and a 24-bit register address. The target then answers with status bytes. Bit D0 of a status byte stays 0 while the requested data is not yet available, and one byte of value 0x01 marks that the data bytes start with the next byte. On a read, the data bytes come back on MISO. On a write, the data bytes are collected and handed to the internal register file as one word once the last byte has arrived.

All SPI pins are oversampled by the fast system clock. The internal register file sits behind a single valid/ready handshake that carries a whole transfer word. When a transaction is finished and the target can take the next one, it drives an active-low ready pulse. The pulse has a short width by default and a long width when a bit in a local configuration register is set. That register sits at a fixed SPI address and is handled inside the block.

Top module: `tpm_spi_target`

## Requirements
- R1: Out of reset `rdy_int_n` is 1, `spi_miso` is 0 and `reg_valid` is 0; `spi_miso` is 0 whenever `spi_cs_n` is high.
- R2: Header byte 0 bit 7 is 1 for a read and 0 for a write, and its bits 5:0 hold the data length minus one. Header bytes 1 to 3 carry the address, most significant byte first. A request on the register port shows that address on `reg_addr`, the length minus one on `reg_size`, and `reg_write` = 1 for a write.
- R3: For a read of a non-local address, a request is raised after the fourth header byte. Every status byte that starts before the request's handshake reads 0x00. The first status byte that starts after the handshake reads 0x01. With a handshake that completes at once, the first status byte is 0x01.
- R4: After the 0x01 byte, a read returns `reg_rdata` byte k (bits 8k+7:8k) as data byte k, for k from 0 upward. Each byte is sent most significant bit first.
- R5: On a write, the first status byte is 0x01. After the last data byte, exactly one write request is raised, with data byte k placed in `reg_wdata` bits 8k+7:8k.
- R6: With configuration bit 0 clear, `rdy_int_n` goes low for exactly SHORT_CYC system clock cycles once per completed transaction. For a read, the pulse follows the last data byte. For a non-local write, it follows the handshake of the write request.
- R7: The configuration register at CFG_ADDR (default 0xD40FE0) never reaches the register port. A write to it stores bit 0 of data byte 0, and a read returns that bit in data byte 0. While the bit is 1, ready pulses last exactly LONG_CYC cycles, including the pulse that ends the write that sets the bit.
- R8: If `spi_cs_n` rises before the last data byte, the transaction is dropped. No write request is raised and no ready pulse follows.
- R9: While `reg_valid` is 1 and `reg_ready` is 0, `reg_valid`, `reg_write` and `reg_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host to target data |
| spi_miso | output | 1 | Target to host data |
| rdy_int_n | output | 1 | Active-low ready pulse |
| reg_valid | output | 1 | Register access request |
| reg_ready | input | 1 | Register file accepts the request |
| reg_write | output | 1 | 1 for write, 0 for read |
| reg_addr | output | 24 | Register address |
| reg_size | output | 6 | Transfer length minus one |
| reg_wdata | output | 8*MAX_LEN | Write data, byte k in bits 8k+7:8k |
| reg_rdata | input | 8*MAX_LEN | Read data, valid with reg_ready |

## Verification
The hardest case to reach is a read whose register file answers only after several status bytes have gone by. In that case the bench must see a run of 0x00 bytes that ends in a single 0x01, and the data must still arrive intact. The bench's register model holds `reg_ready` low for a programmable number of cycles, long compared with one SPI byte, and the host task keeps clocking status bytes until it sees the 0x01. The bench also aborts transactions by raising chip select partway through the data phase. It then checks that no write request and no ready pulse follow. The change of pulse width is checked on the same pulse that ends the configuration write.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } txn_state_e;
endpackage

// File: rtl/tpm_spi_sync.sv
module tpm_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_bit
);
  logic [STAGES:0]   sclk_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] mosi_q;
  logic [STAGES:0]   sclk_d;
  logic [STAGES-1:0] cs_d;
  logic [STAGES-1:0] mosi_d;

  always_comb begin
    sclk_d = {sclk_q[STAGES-1:0], sclk_in};
    cs_d   = {cs_q[STAGES-2:0], cs_n_in};
    mosi_d = {mosi_q[STAGES-2:0], mosi_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      mosi_q <= mosi_d;
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_q[STAGES];
  assign cs_act    = ~cs_q[STAGES-1];
  assign mosi_bit  = mosi_q[STAGES-1];
endmodule

// File: rtl/tpm_spi_pulse.sv
module tpm_spi_pulse #(
  parameter int SHORT_CYC = 96,
  parameter int LONG_CYC  = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic long_mode,
  output logic int_n
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic          low_q, low_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    low_d = low_q;
    cnt_d = cnt_q;
    if (!low_q) begin
      if (trig) begin
        low_d = 1'b1;
        cnt_d = long_mode ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
      end
    end else if (cnt_q == '0) begin
      low_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      low_q <= low_d;
      cnt_q <= cnt_d;
    end
  end

  assign int_n = ~low_q;

  // checker: length of the current low phase
  logic [CW:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (!int_n) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R6: a pulse is never shorter than the short width
  p_pulse_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> (run_q >= (CW+1)'(SHORT_CYC)));

  // R6: a pulse only starts after a trigger
  p_fall_after_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(trig));
endmodule

// File: rtl/tpm_spi_txn.sv
module tpm_spi_txn
  import tpm_spi_pkg::*;
#(
  parameter int          MAX_LEN  = 4,
  parameter logic [23:0] CFG_ADDR = 24'hD40FE0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_act,
  input  logic                 sclk_rise,
  input  logic                 sclk_fall,
  input  logic                 mosi_bit,
  output logic                 miso,
  output logic                 reg_valid,
  input  logic                 reg_ready,
  output logic                 reg_write,
  output logic [23:0]          reg_addr,
  output logic [5:0]           reg_size,
  output logic [8*MAX_LEN-1:0] reg_wdata,
  input  logic [8*MAX_LEN-1:0] reg_rdata,
  output logic                 pulse_trig,
  output logic                 long_next
);
  localparam int DW = 8 * MAX_LEN;

  txn_state_e    state_q, state_d;
  logic [1:0]    hidx_q, hidx_d;
  logic [2:0]    bit_q, bit_d;
  logic [6:0]    rx_q, rx_d;
  logic [7:0]    tx_q, tx_d;
  logic          bend_q, bend_d;
  logic          rdy_q, rdy_d;
  logic          rd_q, rd_d;
  logic [5:0]    len_q, len_d;
  logic [23:0]   addr_q, addr_d;
  logic          loc_q, loc_d;
  logic [5:0]    cnt_q, cnt_d;
  logic          have_q, have_d;
  logic [DW-1:0] rbuf_q, rbuf_d;
  logic [DW-1:0] wbuf_q, wbuf_d;
  logic          pend_q, pend_d;
  logic          pwr_q, pwr_d;
  logic          cfg_q, cfg_d;
  logic [7:0]    rx_byte;
  logic [23:0]   addr_full;

  function automatic logic [7:0] pick(input logic [DW-1:0] w, input logic [5:0] k);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < MAX_LEN; i++)
      if (k == 6'(i)) r = w[i*8 +: 8];
    return r;
  endfunction

  assign rx_byte   = {rx_q, mosi_bit};
  assign addr_full = {addr_q[15:0], rx_byte};

  always_comb begin
    state_d = state_q; hidx_d = hidx_q; bit_d = bit_q; rx_d = rx_q;
    tx_d = tx_q; bend_d = bend_q; rdy_d = rdy_q; rd_d = rd_q;
    len_d = len_q; addr_d = addr_q; loc_d = loc_q; cnt_d = cnt_q;
    have_d = have_q; rbuf_d = rbuf_q; wbuf_d = wbuf_q;
    pend_d = pend_q; pwr_d = pwr_q; cfg_d = cfg_q;
    pulse_trig = 1'b0;

    // register port handshake
    if (pend_q && reg_ready) begin
      pend_d = 1'b0;
      if (pwr_q) pulse_trig = 1'b1;
      else if (state_q == ST_WAIT) begin
        have_d = 1'b1;
        rbuf_d = reg_rdata;
      end
    end

    if (!cs_act) begin
      state_d = ST_HDR; hidx_d = '0; bit_d = '0; tx_d = '0;
      bend_d = 1'b0; rdy_d = 1'b0; have_d = 1'b0;
    end else if (sclk_rise) begin
      bit_d  = bit_q + 3'd1;
      rx_d   = rx_byte[6:0];
      bend_d = (bit_q == 3'd7);
      if (bit_q == 3'd7) begin
        unique case (state_q)
          ST_HDR: begin
            hidx_d = hidx_q + 2'd1;
            if (hidx_q == 2'd0) begin
              rd_d  = rx_byte[7];
              len_d = rx_byte[5:0];
            end else begin
              addr_d = addr_full;
            end
            if (hidx_q == 2'd3) begin
              state_d = ST_WAIT;
              rdy_d   = 1'b0;
              cnt_d   = '0;
              have_d  = 1'b0;
              loc_d   = (addr_full == CFG_ADDR);
              if (rd_q && (addr_full == CFG_ADDR)) begin
                have_d = 1'b1;
                rbuf_d = DW'(cfg_q);
              end else if (rd_q) begin
                pend_d = 1'b1;
                pwr_d  = 1'b0;
              end
            end
          end
          ST_WAIT: begin
            if (rdy_q) state_d = ST_DATA;
          end
          ST_DATA: begin
            if (!rd_q)
              for (int i = 0; i < MAX_LEN; i++)
                if (cnt_q == 6'(i)) wbuf_d[i*8 +: 8] = rx_byte;
            if (cnt_q == len_q) begin
              state_d = ST_DONE;
              if (rd_q) pulse_trig = 1'b1;
              else if (loc_q) begin
                cfg_d      = (cnt_q == 6'd0) ? rx_byte[0] : wbuf_q[0];
                pulse_trig = 1'b1;
              end else begin
                pend_d = 1'b1;
                pwr_d  = 1'b1;
              end
            end else begin
              cnt_d = cnt_q + 6'd1;
            end
          end
          default: ;
        endcase
      end
    end else if (sclk_fall) begin
      if (bend_q) begin
        bend_d = 1'b0;
        unique case (state_q)
          ST_WAIT: begin
            if (have_q || !rd_q) begin
              tx_d  = 8'h01;
              rdy_d = 1'b1;
            end else begin
              tx_d = 8'h00;
            end
          end
          ST_DATA: tx_d = rd_q ? pick(rbuf_q, cnt_q) : 8'h00;
          default: tx_d = 8'h00;
        endcase
      end else begin
        tx_d = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR; hidx_q <= '0; bit_q <= '0; rx_q <= '0;
      tx_q <= '0; bend_q <= 1'b0; rdy_q <= 1'b0; rd_q <= 1'b0;
      len_q <= '0; addr_q <= '0; loc_q <= 1'b0; cnt_q <= '0;
      have_q <= 1'b0; rbuf_q <= '0; wbuf_q <= '0;
      pend_q <= 1'b0; pwr_q <= 1'b0; cfg_q <= 1'b0;
    end else begin
      state_q <= state_d; hidx_q <= hidx_d; bit_q <= bit_d; rx_q <= rx_d;
      tx_q <= tx_d; bend_q <= bend_d; rdy_q <= rdy_d; rd_q <= rd_d;
      len_q <= len_d; addr_q <= addr_d; loc_q <= loc_d; cnt_q <= cnt_d;
      have_q <= have_d; rbuf_q <= rbuf_d; wbuf_q <= wbuf_d;
      pend_q <= pend_d; pwr_q <= pwr_d; cfg_q <= cfg_d;
    end
  end

  assign miso      = tx_q[7];
  assign reg_valid = pend_q;
  assign reg_write = pwr_q;
  assign reg_addr  = addr_q;
  assign reg_size  = len_q;
  assign reg_wdata = wbuf_q;
  assign long_next = cfg_d;

  // R9: a waiting request keeps its fields
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) && $stable(reg_write)));

  // R8: a write request only arises from a finished data phase
  p_wr_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_valid) && reg_write) |-> ($past(state_q) == ST_DATA));
endmodule

// File: rtl/tpm_spi_target.sv
module tpm_spi_target #(
  parameter int          MAX_LEN     = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int          SHORT_CYC   = 96,
  parameter int          LONG_CYC    = 2400,
  parameter logic [23:0] CFG_ADDR    = 24'hD40FE0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  output logic                 rdy_int_n,
  output logic                 reg_valid,
  input  logic                 reg_ready,
  output logic                 reg_write,
  output logic [23:0]          reg_addr,
  output logic [5:0]           reg_size,
  output logic [8*MAX_LEN-1:0] reg_wdata,
  input  logic [8*MAX_LEN-1:0] reg_rdata
);
  logic sclk_rise, sclk_fall, cs_act, mosi_bit;
  logic pulse_trig, long_next;

  tpm_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .mosi_bit(mosi_bit)
  );

  tpm_spi_txn #(.MAX_LEN(MAX_LEN), .CFG_ADDR(CFG_ADDR)) u_txn (
    .clk(clk), .rst_n(rst_n),
    .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mosi_bit(mosi_bit), .miso(spi_miso),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pulse_trig(pulse_trig), .long_next(long_next)
  );

  tpm_spi_pulse #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n),
    .trig(pulse_trig), .long_mode(long_next), .int_n(rdy_int_n)
  );
endmodule

// File: tb/tpm_spi_target_tb.sv
module tpm_spi_target_tb;
  localparam int H     = 32;
  localparam int SHORT = 96;
  localparam int LONG  = 2400;
  localparam logic [23:0] CFGA = 24'hD40FE0;

  logic clk, rst_n, sclk, cs_n, mosi, miso, int_n;
  logic reg_valid, reg_ready, reg_write;
  logic [23:0] reg_addr;
  logic [5:0]  reg_size;
  logic [31:0] reg_wdata, reg_rdata;

  int checks = 0, errors = 0;
  int lat = 0, wcnt = 0;
  int req_cnt = 0, wr_cnt = 0, hold_err = 0;
  logic hold_pend = 1'b0;
  logic [23:0] hold_addr, last_addr;
  logic [5:0]  last_size;
  logic        last_wr;
  logic [31:0] last_wdata;
  int pulses = 0, run = 0, last_len = 0;
  bit done = 0;

  tpm_spi_target u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .rdy_int_n(int_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_size(reg_size),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // register file model and handshake monitor
  always @(negedge clk) begin
    if (hold_pend && !(reg_valid && reg_addr == hold_addr)) hold_err++;
    if (reg_ready) reg_ready = 1'b0;
    else if (reg_valid) begin
      if (wcnt >= lat) begin
        reg_ready = 1'b1; wcnt = 0; req_cnt++;
        last_addr = reg_addr; last_size = reg_size; last_wr = reg_write;
        if (reg_write) begin wr_cnt++; last_wdata = reg_wdata; end
      end else wcnt++;
    end
    hold_pend = reg_valid && !reg_ready;
    hold_addr = reg_addr;
  end

  // ready pulse monitor
  always @(negedge clk) begin
    if (rst_n && !int_n) run++;
    else if (run > 0) begin last_len = run; pulses++; run = 0; end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      hp(H);
      rx[i] = miso;
      sclk = 1'b1;
      hp(H);
      sclk = 1'b0;
    end
  endtask

  task automatic header(input bit rd, input int len, input logic [23:0] a);
    logic [7:0] d;
    cs_n = 1'b0;
    hp(H);
    spi_byte({rd, 1'b0, 6'(len - 1)}, d);
    spi_byte(a[23:16], d);
    spi_byte(a[15:8], d);
    spi_byte(a[7:0], d);
  endtask

  task automatic finish_txn();
    hp(H);
    cs_n = 1'b1;
    hp(4 * H);
  endtask

  task automatic status(output int zeros, output logic [7:0] last);
    logic [7:0] b;
    zeros = 0;
    spi_byte(8'h00, b);
    while (b == 8'h00 && zeros < 20) begin zeros++; spi_byte(8'h00, b); end
    last = b;
  endtask

  task automatic do_read(input int len, input logic [23:0] a, output int zeros,
                         output logic [7:0] st, output logic [31:0] data);
    logic [7:0] b;
    data = '0;
    header(1'b1, len, a);
    status(zeros, st);
    for (int k = 0; k < len; k++) begin
      spi_byte(8'h00, b);
      data[k*8 +: 8] = b;
    end
    finish_txn();
  endtask

  task automatic do_write(input int len, input logic [23:0] a, input logic [31:0] w,
                          output logic [7:0] first);
    logic [7:0] b;
    header(1'b0, len, a);
    spi_byte(8'h00, first);
    for (int k = 0; k < len; k++) spi_byte(w[k*8 +: 8], b);
    finish_txn();
  endtask

  task automatic t_reset();
    check(int_n === 1'b1, "R1 int_n after reset", int_n, 1);
    check(miso === 1'b0, "R1 miso after reset", miso, 0);
    check(reg_valid === 1'b0, "R1 reg_valid after reset", reg_valid, 0);
  endtask

  task automatic t_read_fast();
    int z, p0; logic [7:0] st; logic [31:0] d;
    lat = 0; reg_rdata = 32'hE01A2800; p0 = pulses;
    do_read(4, 24'hD40F00, z, st, d);
    hp(3 * SHORT);
    check(z == 0 && st == 8'h01, "R3 immediate ready byte", {z, st}, 1);
    check(d == 32'hE01A2800, "R4 read data order", d, 32'hE01A2800);
    check(last_addr == 24'hD40F00 && !last_wr && last_size == 6'd3,
          "R2 header decode read", {last_addr, last_size}, {24'hD40F00, 6'd3});
    check(pulses == p0 + 1 && last_len == SHORT, "R6 short pulse after read", last_len, SHORT);
  endtask

  task automatic t_read_slow();
    int z, p0; logic [7:0] st; logic [31:0] d;
    lat = 1500; reg_rdata = 32'h0000C35A; p0 = pulses;
    do_read(2, 24'h00ABCD, z, st, d);
    hp(3 * SHORT);
    lat = 0;
    check(z >= 2 && st == 8'h01, "R3 wait bytes before ready", z, 2);
    check(d[15:0] == 16'hC35A, "R4 read data after wait", d[15:0], 16'hC35A);
    check(pulses == p0 + 1, "R6 one pulse per read", pulses - p0, 1);
    check(hold_err == 0, "R9 request held while not ready", hold_err, 0);
  endtask

  task automatic t_write();
    int p0, w0; logic [7:0] f;
    lat = 50; p0 = pulses; w0 = wr_cnt;
    do_write(3, 24'h000123, 32'h00CCBBAA, f);
    hp(3 * SHORT);
    lat = 0;
    check(f == 8'h01, "R5 write ready byte", f, 1);
    check(wr_cnt == w0 + 1 && last_wdata[23:0] == 24'hCCBBAA, "R5 write data packing",
          last_wdata[23:0], 24'hCCBBAA);
    check(last_addr == 24'h000123 && last_wr && last_size == 6'd2, "R2 header decode write",
          {last_addr, last_size}, {24'h000123, 6'd2});
    check(pulses == p0 + 1 && last_len == SHORT, "R6 pulse after write", last_len, SHORT);
  endtask

  task automatic t_abort();
    int p0, w0; logic [7:0] b;
    p0 = pulses; w0 = wr_cnt;
    header(1'b0, 3, 24'h000456);
    spi_byte(8'h00, b);
    spi_byte(8'h11, b);
    finish_txn();
    hp(3 * SHORT);
    check(wr_cnt == w0, "R8 aborted write not committed", wr_cnt - w0, 0);
    check(pulses == p0, "R8 no pulse after aborted write", pulses - p0, 0);
    check(miso === 1'b0, "R1 miso idle with cs high", miso, 0);
    reg_rdata = 32'h12345678;
    header(1'b1, 4, 24'h000010);
    spi_byte(8'h00, b);
    spi_byte(8'h00, b);
    finish_txn();
    hp(3 * SHORT);
    check(pulses == p0, "R8 no pulse after aborted read", pulses - p0, 0);
  endtask

  task automatic t_config();
    int p0, r0, z; logic [7:0] f, st; logic [31:0] d;
    p0 = pulses; r0 = req_cnt;
    do_write(1, CFGA, 32'h1, f);
    hp(LONG + 200);
    check(req_cnt == r0, "R7 config write stays local", req_cnt - r0, 0);
    check(pulses == p0 + 1 && last_len == LONG, "R7 long pulse after setting bit", last_len, LONG);
    do_read(1, CFGA, z, st, d);
    hp(LONG + 200);
    check(d[7:0] == 8'h01 && z == 0, "R7 config read back", d[7:0], 1);
    check(req_cnt == r0, "R7 config read stays local", req_cnt - r0, 0);
    reg_rdata = 32'h0;
    do_read(1, 24'h000020, z, st, d);
    hp(LONG + 200);
    check(last_len == LONG, "R7 long pulse on plain read", last_len, LONG);
    do_write(1, CFGA, 32'h0, f);
    hp(3 * SHORT);
    check(last_len == SHORT, "R7 short pulse after clearing bit", last_len, SHORT);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    reg_ready = 1'b0; reg_rdata = '0;
    hp(5);
    rst_n = 1'b1;
    hp(5);
    t_reset();
    t_read_fast();
    t_read_slow();
    t_write();
    t_abort();
    t_config();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule